// File: doc/BRIEF.md
# LIN Master Header Transmitter

This block drives the header of a LIN master frame onto one serial transmit line. A header job sends a 13-bit dominant break, one recessive delimiter bit, the 0x55 sync character and the protected identifier character. The two characters are sent as start bit, eight data bits LSB first, then stop bit. The block can also send a break on its own or a 10-bit recessive idle character on its own. An enable input places an idle character ahead of the break.

The bit time is a whole number of system clock cycles. The divider value sets that number, and the block captures it when it accepts a job. For 19200 baud from an 8 MHz clock, set the divider to 417. The bit counter restarts on the clock edge that accepts the job. The first bit therefore always starts exactly at that edge, and the break never lasts longer than 13 bit times, whatever the phase of the request. The block ignores any request that arrives while it is busy.

Top module: `lin_hdr_tx`

## Requirements
- R1: After reset, tx_o is high (recessive), busy_o is low and done_o is low.
- R2: A header job starts the break at the accept edge, which is the first rising clock edge that samples the request while the block is idle. The break holds tx_o low for exactly 13 bit times.
- R3: One recessive delimiter bit follows the break. The sync start bit comes right after it, with no other gap.
- R4: The sync character is a low start bit, then 0x55 LSB first, then a high stop bit: 10 bit times in all.
- R5: The identifier character is a low start bit, then the byte on pid_i LSB first, then a high stop bit. The identifier byte is the one present at the accept edge.
- R6: If idle_first_i is high at the accept edge of a header or break job, 10 recessive bit times come before the break.
- R7: busy_o is high from the accept edge until the last bit ends. done_o is then high for exactly one cycle while busy_o is low. A header lasts 34 bit times, or 44 with the idle character.
- R8: A break-only job sends the 13 low bits and the 1 high delimiter bit, then finishes.
- R9: An idle-only job sends 10 high bit times, then finishes.
- R10: Any request that arrives while busy_o is high is ignored. The transmitted stream does not change.
- R11: When several requests arrive in the same cycle, a header beats a break and a break beats an idle.
- R12: Each bit lasts baud_div_i cycles, using the divider value captured at the accept edge. A value of 0 acts as 1. Changing the divider during a job has no effect on that job.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| hdr_req_i | input | 1 | Request a full header |
| brk_req_i | input | 1 | Request a break with delimiter only |
| idle_req_i | input | 1 | Request a single idle character |
| idle_first_i | input | 1 | Send an idle character before the break |
| pid_i | input | 8 | Protected identifier byte |
| baud_div_i | input | DIV_W | Cycles per bit |
| tx_o | output | 1 | Serial line, high is recessive |
| busy_o | output | 1 | A job is in progress |
| done_o | output | 1 | One-cycle pulse when a job ends |

## Verification
Take the accept edge as cycle 0. Bit k then holds on tx_o from cycle k·D up to, but not including, cycle (k+1)·D, where D is the captured divider. busy_o falls and done_o rises at cycle N·D, where N is the job's bit count, and done_o falls one cycle later. The bench drives each request for one half-period before an edge. It then samples tx_o, busy_o and done_o at the falling edge after every cycle, so sample j shows the state after edge j. Each expected bit is compared against all D of its samples. The busy and done checks are made at samples N·D and N·D+1.

// File: rtl/lin_hdr_pkg.sv
package lin_hdr_pkg;

    typedef enum logic [2:0] {
        SEG_OFF,
        SEG_IDLE,
        SEG_BRK,
        SEG_DELIM,
        SEG_SYNC,
        SEG_PID
    } seg_e;

    typedef enum logic [1:0] {
        JOB_HDR,
        JOB_BRK,
        JOB_IDLE
    } job_e;

    localparam int CHAR_BITS = 10;
    localparam int BRK_BITS  = 13;
    localparam int DLM_BITS  = 1;
    localparam int BITN_W    = $clog2(BRK_BITS);
    localparam logic [7:0] SYNC_BYTE = 8'h55;

    typedef struct packed {
        seg_e                   seg;
        logic [BITN_W-1:0]      bitn;
        logic [CHAR_BITS-1:0]   sh;
        job_e                   job;
        logic [7:0]             pid;
        logic                   busy;
        logic                   done;
    } seq_t;

    // index of the last bit of each segment
    function automatic logic [BITN_W-1:0] seg_last(seg_e s);
        case (s)
            SEG_IDLE, SEG_SYNC, SEG_PID: seg_last = BITN_W'(CHAR_BITS - 1);
            SEG_BRK:                     seg_last = BITN_W'(BRK_BITS - 1);
            SEG_DELIM:                   seg_last = BITN_W'(DLM_BITS - 1);
            default:                     seg_last = '0;
        endcase
    endfunction

    // line levels of a segment, bit 0 goes out first
    function automatic logic [CHAR_BITS-1:0] seg_pattern(seg_e s, logic [7:0] pid);
        case (s)
            SEG_BRK:  seg_pattern = '0;
            SEG_SYNC: seg_pattern = {1'b1, SYNC_BYTE, 1'b0};
            SEG_PID:  seg_pattern = {1'b1, pid, 1'b0};
            default:  seg_pattern = '1;
        endcase
    endfunction

    function automatic seg_e seg_after(seg_e s, job_e j);
        case (s)
            SEG_IDLE:  seg_after = (j == JOB_IDLE) ? SEG_OFF : SEG_BRK;
            SEG_BRK:   seg_after = SEG_DELIM;
            SEG_DELIM: seg_after = (j == JOB_BRK) ? SEG_OFF : SEG_SYNC;
            SEG_SYNC:  seg_after = SEG_PID;
            default:   seg_after = SEG_OFF;
        endcase
    endfunction

endpackage

// File: rtl/lin_baud_gen.sv
module lin_baud_gen #(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart_i,
    input  logic             run_i,
    input  logic [DIV_W-1:0] div_i,
    output logic             tick_o
);

    typedef struct packed {
        logic [DIV_W-1:0] cnt;
        logic [DIV_W-1:0] div;
    } baud_t;

    baud_t q_q, q_d;
    logic  last_cyc;

    assign last_cyc = (q_q.cnt == q_q.div - DIV_W'(1));
    assign tick_o   = run_i && last_cyc;

    always_comb begin
        q_d = q_q;
        if (restart_i) begin
            q_d.cnt = '0;
            q_d.div = (div_i == '0) ? DIV_W'(1) : div_i;
        end else if (run_i) begin
            q_d.cnt = last_cyc ? '0 : q_q.cnt + DIV_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q_q <= '{cnt: '0, div: DIV_W'(1)};
        end else begin
            q_q <= q_d;
        end
    end

    assert_cnt_range_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (q_q.div != '0) && (q_q.cnt < q_q.div));

    assert_div_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (run_i && !restart_i) |=> $stable(q_q.div));

endmodule

// File: rtl/lin_hdr_seq.sv
module lin_hdr_seq
    import lin_hdr_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start_i,
    input  job_e       job_i,
    input  logic       idle_first_i,
    input  logic [7:0] pid_i,
    input  logic       tick_i,
    output logic       tx_o,
    output logic       busy_o,
    output logic       done_o
);

    seq_t q_q, q_d;
    seg_e first_seg;
    seg_e next_seg;

    always_comb begin
        q_d       = q_q;
        q_d.done  = 1'b0;
        first_seg = (job_i == JOB_IDLE || idle_first_i) ? SEG_IDLE : SEG_BRK;
        next_seg  = seg_after(q_q.seg, q_q.job);
        if (!q_q.busy) begin
            if (start_i) begin
                q_d.busy = 1'b1;
                q_d.job  = job_i;
                q_d.pid  = pid_i;
                q_d.seg  = first_seg;
                q_d.bitn = '0;
                q_d.sh   = seg_pattern(first_seg, pid_i);
            end
        end else if (tick_i) begin
            if (q_q.bitn == seg_last(q_q.seg)) begin
                q_d.bitn = '0;
                q_d.seg  = next_seg;
                q_d.sh   = seg_pattern(next_seg, q_q.pid);
                if (next_seg == SEG_OFF) begin
                    q_d.busy = 1'b0;
                    q_d.done = 1'b1;
                end
            end else begin
                q_d.bitn = q_q.bitn + BITN_W'(1);
                q_d.sh   = {q_q.sh[CHAR_BITS-1], q_q.sh[CHAR_BITS-1:1]};
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q_q <= '{seg: SEG_OFF, bitn: '0, sh: '1, job: JOB_HDR,
                     pid: '0, busy: 1'b0, done: 1'b0};
        end else begin
            q_q <= q_d;
        end
    end

    assign tx_o   = q_q.busy ? q_q.sh[0] : 1'b1;
    assign busy_o = q_q.busy;
    assign done_o = q_q.done;

    assert_break_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (q_q.busy && q_q.seg == SEG_BRK) |-> !tx_o);

    assert_delim_high_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (q_q.busy && q_q.seg == SEG_DELIM) |-> tx_o);

    assert_seg_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (q_q.busy && !tick_i) |=> ($stable(q_q.seg) && $stable(q_q.bitn)));

    assert_job_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        q_q.busy |=> ($stable(q_q.job) && $stable(q_q.pid)));

    assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    assert_done_not_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (!busy_o && $past(busy_o)));

endmodule

// File: rtl/lin_hdr_tx.sv
module lin_hdr_tx
    import lin_hdr_pkg::*;
#(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hdr_req_i,
    input  logic             brk_req_i,
    input  logic             idle_req_i,
    input  logic             idle_first_i,
    input  logic [7:0]       pid_i,
    input  logic [DIV_W-1:0] baud_div_i,
    output logic             tx_o,
    output logic             busy_o,
    output logic             done_o
);

    logic accept;
    logic tick;
    job_e job_sel;

    assign accept  = !busy_o && (hdr_req_i || brk_req_i || idle_req_i);
    assign job_sel = hdr_req_i ? JOB_HDR : (brk_req_i ? JOB_BRK : JOB_IDLE);

    lin_baud_gen #(.DIV_W(DIV_W)) u_baud (
        .clk       (clk),
        .rst_n     (rst_n),
        .restart_i (accept),
        .run_i     (busy_o),
        .div_i     (baud_div_i),
        .tick_o    (tick)
    );

    lin_hdr_seq u_seq (
        .clk          (clk),
        .rst_n        (rst_n),
        .start_i      (accept),
        .job_i        (job_sel),
        .idle_first_i (idle_first_i),
        .pid_i        (pid_i),
        .tick_i       (tick),
        .tx_o         (tx_o),
        .busy_o       (busy_o),
        .done_o       (done_o)
    );

    assert_accept_starts_R7: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> (busy_o && !done_o));

    assert_idle_line_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && !$past(busy_o)) |-> tx_o);

endmodule

// File: tb/lin_hdr_tx_tb.sv
module lin_hdr_tx_tb;

    localparam int DIV_W = 16;
    localparam int MAXS  = 4096;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             hdr_req = 1'b0;
    logic             brk_req = 1'b0;
    logic             idle_req = 1'b0;
    logic             idle_first = 1'b0;
    logic [7:0]       pid = 8'h00;
    logic [DIV_W-1:0] div = DIV_W'(4);
    logic             tx, busy, done;

    int n_chk = 0;
    int n_err = 0;

    logic  exp_lvl [0:63];
    string exp_tag [0:63];
    int    nexp;
    logic  tx_s [0:MAXS-1];
    logic  busy_s [0:MAXS-1];
    logic  done_s [0:MAXS-1];

    always #10 clk = ~clk;

    lin_hdr_tx #(.DIV_W(DIV_W)) u_dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .hdr_req_i    (hdr_req),
        .brk_req_i    (brk_req),
        .idle_req_i   (idle_req),
        .idle_first_i (idle_first),
        .pid_i        (pid),
        .baud_div_i   (div),
        .tx_o         (tx),
        .busy_o       (busy),
        .done_o       (done)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int expv);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, expv);
        end
    endtask

    task automatic exp_clear();
        nexp = 0;
    endtask

    task automatic exp_bits(input logic lvl, input int n, input string tag);
        for (int k = 0; k < n; k++) begin
            exp_lvl[nexp] = lvl;
            exp_tag[nexp] = tag;
            nexp++;
        end
    endtask

    task automatic exp_char(input logic [7:0] b, input string tag);
        exp_bits(1'b0, 1, tag);
        for (int k = 0; k < 8; k++) exp_bits(b[k], 1, tag);
        exp_bits(1'b1, 1, tag);
    endtask

    // drive one request cycle, record, then check every bit and the end of job
    task automatic run_job(input logic h, input logic b, input logic i,
                           input int deff, input int dis, input string jtag);
        int total;
        total = nexp * deff;
        @(negedge clk);
        hdr_req = h; brk_req = b; idle_req = i;
        @(negedge clk);
        hdr_req = 1'b0; brk_req = 1'b0; idle_req = 1'b0;
        for (int j = 0; j <= total + 1; j++) begin
            tx_s[j] = tx; busy_s[j] = busy; done_s[j] = done;
            if (j == dis) begin
                hdr_req = 1'b1; brk_req = 1'b1; idle_req = 1'b1;
                pid = ~pid; div = div + DIV_W'(3); idle_first = ~idle_first;
            end else if (j == dis + 1) begin
                hdr_req = 1'b0; brk_req = 1'b0; idle_req = 1'b0;
            end
            @(negedge clk);
        end
        for (int k = 0; k < nexp; k++) begin
            bit ok = 1'b1;
            int act = exp_lvl[k];
            for (int s = k * deff; s < (k + 1) * deff; s++) begin
                if (tx_s[s] !== exp_lvl[k]) begin
                    ok = 1'b0;
                    act = int'(tx_s[s]);
                end
            end
            chk(ok, exp_tag[k], $sformatf("%s bit %0d level", jtag, k), act, int'(exp_lvl[k]));
        end
        begin
            bit ok = 1'b1;
            for (int s = 0; s < total; s++)
                if (busy_s[s] !== 1'b1 || done_s[s] !== 1'b0) ok = 1'b0;
            chk(ok, "R7", {jtag, " busy held, done low during job"}, int'(ok), 1);
        end
        chk(busy_s[total] === 1'b0, "R7", {jtag, " busy low at end"}, int'(busy_s[total]), 0);
        chk(done_s[total] === 1'b1, "R7", {jtag, " done pulse at end"}, int'(done_s[total]), 1);
        chk(done_s[total+1] === 1'b0, "R7", {jtag, " done one cycle"}, int'(done_s[total+1]), 0);
        chk(tx_s[total] === 1'b1, "R7", {jtag, " line recessive after job"}, int'(tx_s[total]), 1);
        repeat (3) @(negedge clk);
    endtask

    task automatic t_reset();
        chk(tx === 1'b1, "R1", "tx after reset", int'(tx), 1);
        chk(busy === 1'b0, "R1", "busy after reset", int'(busy), 0);
        chk(done === 1'b0, "R1", "done after reset", int'(done), 0);
    endtask

    task automatic t_header();
        idle_first = 1'b0; pid = 8'hA3; div = DIV_W'(4);
        exp_clear();
        exp_bits(1'b0, 13, "R2"); exp_bits(1'b1, 1, "R3");
        exp_char(8'h55, "R4"); exp_char(8'hA3, "R5");
        run_job(1'b1, 1'b0, 1'b0, 4, -5, "header");
    endtask

    task automatic t_header_idle();
        idle_first = 1'b1; pid = 8'h3C; div = DIV_W'(5);
        exp_clear();
        exp_bits(1'b1, 10, "R6"); exp_bits(1'b0, 13, "R6"); exp_bits(1'b1, 1, "R3");
        exp_char(8'h55, "R4"); exp_char(8'h3C, "R5");
        run_job(1'b1, 1'b0, 1'b0, 5, -5, "header+idle");
        idle_first = 1'b0;
    endtask

    task automatic t_break_only();
        div = DIV_W'(3);
        exp_clear();
        exp_bits(1'b0, 13, "R8"); exp_bits(1'b1, 1, "R8");
        run_job(1'b0, 1'b1, 1'b0, 3, -5, "break");
        idle_first = 1'b1;
        exp_clear();
        exp_bits(1'b1, 10, "R6"); exp_bits(1'b0, 13, "R8"); exp_bits(1'b1, 1, "R8");
        run_job(1'b0, 1'b1, 1'b0, 3, -5, "idle+break");
        idle_first = 1'b0;
    endtask

    task automatic t_idle_only();
        div = DIV_W'(3);
        exp_clear();
        exp_bits(1'b1, 10, "R9");
        run_job(1'b0, 1'b0, 1'b1, 3, -5, "idle");
    endtask

    task automatic t_busy_ignore();
        idle_first = 1'b0; pid = 8'h96; div = DIV_W'(2);
        exp_clear();
        exp_bits(1'b0, 13, "R10"); exp_bits(1'b1, 1, "R10");
        exp_char(8'h55, "R10"); exp_char(8'h96, "R10");
        run_job(1'b1, 1'b0, 1'b0, 2, 20, "busy-ignore R12");
        idle_first = 1'b0;
    endtask

    task automatic t_priority();
        idle_first = 1'b0; pid = 8'h0F; div = DIV_W'(2);
        exp_clear();
        exp_bits(1'b0, 13, "R11"); exp_bits(1'b1, 1, "R11");
        exp_char(8'h55, "R11"); exp_char(8'h0F, "R11");
        run_job(1'b1, 1'b1, 1'b1, 2, -5, "all requests");
        exp_clear();
        exp_bits(1'b0, 13, "R11"); exp_bits(1'b1, 1, "R11");
        run_job(1'b0, 1'b1, 1'b1, 2, -5, "break+idle requests");
    endtask

    task automatic t_div_zero();
        idle_first = 1'b0; div = '0;
        exp_clear();
        exp_bits(1'b0, 13, "R12"); exp_bits(1'b1, 1, "R12");
        run_job(1'b0, 1'b1, 1'b0, 1, -5, "divider zero");
        div = DIV_W'(1); pid = 8'h5A;
        exp_clear();
        exp_bits(1'b0, 13, "R12"); exp_bits(1'b1, 1, "R12");
        exp_char(8'h55, "R12"); exp_char(8'h5A, "R12");
        run_job(1'b1, 1'b0, 1'b0, 1, -5, "divider one");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_header();
        t_header_idle();
        t_break_only();
        t_idle_only();
        t_busy_ignore();
        t_priority();
        t_div_zero();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_err++;
        $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule